// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a 32-bit register datapath and a 32-bit, byte-addressed data memory that stores words most significant byte first. It adds a sign-extended 16-bit displacement to a 32-bit base register to form the effective address. The two low bits of that address pick the byte lanes that take part in the access.

For a store, the block takes the register value and the access size (byte, halfword or word). It produces a write word that carries the operand in every lane, together with four byte enables that mark the lanes to be written. For a load, it takes the memory read word and returns the selected byte or halfword in the low-order bits of the result. The upper bits are filled with the loaded sign bit or with zeroes.

The unit also flags any halfword or word access that does not fall on its own size boundary. When that flag is set, the block suppresses every byte enable. The block is purely combinational and has no state.

Top module: `be_lsu_align`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `disp` sign-extended to 32 bits, modulo 2^32.
- R2: The size code `acc_size` is decoded as follows: 00 is byte, 01 is halfword, and both 10 and 11 are word.
- R3: Byte access: address offset 0 maps to bits 31:24, 1 to bits 23:16, 2 to bits 15:8 and 3 to bits 7:0. `byte_en` is one-hot, and bit 3 of `byte_en` enables bits 31:24 (so offset k sets bit 3-k).
- R4: Halfword access: when address bit 1 is 0, the halfword is bits 31:16 and `byte_en` is 1100. When address bit 1 is 1, the halfword is bits 15:0 and `byte_en` is 0011. The byte at the lower address is the upper half of the halfword.
- R5: An aligned word access sets `byte_en` to 1111 and passes `st_data` unchanged to `wr_data`.
- R6: Store data is replicated into every lane. A byte store gives `wr_data` = four copies of `st_data[7:0]`. A halfword store gives two copies of `st_data[15:0]`.
- R7: When `ld_unsigned` is 0, a byte or halfword load fills the upper bits of `ld_result` with copies of the loaded sign bit.
- R8: When `ld_unsigned` is 1, a byte or halfword load fills the upper bits of `ld_result` with zeroes.
- R9: A word load returns `rd_word` unchanged, whatever the value of `ld_unsigned`.
- R10: `misalign` is 1 in two cases: a halfword with address bit 0 set, or a word with either of the two low address bits set. It is never 1 for a byte access.
- R11: While `misalign` is 1, `byte_en` is 0000. In that case `ld_result` still follows the lane rules: a halfword uses address bit 1 only, and a word ignores the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_addr | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| acc_size | input | 2 | Access size code |
| ld_unsigned | input | 1 | Zero-extend a byte or halfword load |
| st_data | input | 32 | Register value to store |
| rd_word | input | 32 | Word read from memory |
| eff_addr | output | 32 | Effective byte address |
| wr_data | output | 32 | Lane-replicated write word |
| byte_en | output | 4 | Write enables, bit 3 = bits 31:24 |
| ld_result | output | 32 | Extended load result |
| misalign | output | 1 | Access not on its size boundary |

## Verification
Address generation and lane steering always act in the same evaluation, because the lane offset is taken from the sum and not from the base. The bench targets each offset from bases paired with both positive and negative displacements, so that carries and borrows from the addition decide the lanes. Every result is judged against a four-byte array model. Load results are read from the array in big-endian order. Store results are judged by merging the enabled lanes of `wr_data` into a copy of the array and comparing it with the array expected after the access.

// File: rtl/be_lsu_align.sv
module be_lsu_align #(
  parameter int AW     = 32,
  parameter int DISP_W = 16
) (
  input  logic [AW-1:0]     base_addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        acc_size,
  input  logic              ld_unsigned,
  input  logic [31:0]       st_data,
  input  logic [31:0]       rd_word,
  output logic [AW-1:0]     eff_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        byte_en,
  output logic [31:0]       ld_result,
  output logic              misalign
);
  localparam int EXT_W = AW - DISP_W;

  logic [1:0] off;
  logic       sz_byte, sz_half, sz_word;
  logic [7:0] sel_b;
  logic [15:0] sel_h;
  logic [3:0] en_raw;

  assign eff_addr = base_addr + {{EXT_W{disp[DISP_W-1]}}, disp};
  assign off      = eff_addr[1:0];

  assign sz_byte = (acc_size == 2'b00);
  assign sz_half = (acc_size == 2'b01);
  assign sz_word = acc_size[1];

  assign misalign = (sz_half & off[0]) | (sz_word & (|off));

  always_comb begin
    case (off)
      2'd0:    sel_b = rd_word[31:24];
      2'd1:    sel_b = rd_word[23:16];
      2'd2:    sel_b = rd_word[15:8];
      default: sel_b = rd_word[7:0];
    endcase
  end

  assign sel_h = off[1] ? rd_word[15:0] : rd_word[31:16];

  always_comb begin
    if (sz_byte)
      ld_result = {{24{~ld_unsigned & sel_b[7]}}, sel_b};
    else if (sz_half)
      ld_result = {{16{~ld_unsigned & sel_h[15]}}, sel_h};
    else
      ld_result = rd_word;
  end

  always_comb begin
    if (sz_byte)      en_raw = 4'b1000 >> off;
    else if (sz_half) en_raw = off[1] ? 4'b0011 : 4'b1100;
    else              en_raw = 4'b1111;
  end

  assign byte_en = misalign ? 4'b0000 : en_raw;

  assign wr_data = sz_byte ? {4{st_data[7:0]}} :
                   sz_half ? {2{st_data[15:0]}} : st_data;

  always_comb begin
    // R11
    if (misalign) begin
      misalign_no_write_chk: assert (byte_en == 4'b0000);
    end
    // R3
    if (sz_byte) begin
      byte_onehot_chk: assert ($countones(byte_en) == 1 && !misalign);
    end
    // R5
    if (sz_word && off == 2'b00) begin
      word_full_chk: assert (byte_en == 4'b1111 && wr_data == st_data);
    end
    // R8
    if (ld_unsigned && sz_byte) begin
      ubyte_zero_chk: assert (ld_result[31:8] == 24'h0);
    end
    // R7
    if (!ld_unsigned && sz_half) begin
      shalf_sign_chk: assert (ld_result[31:16] == {16{ld_result[15]}});
    end
    // R9
    if (sz_word) begin
      word_pass_chk: assert (ld_result == rd_word);
    end
  end
endmodule

// File: tb/test_be_lsu_align.sv
module test_be_lsu_align;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] base_addr;
  logic [15:0] disp;
  logic [1:0]  acc_size;
  logic        ld_unsigned;
  logic [31:0] st_data, rd_word;
  logic [31:0] eff_addr, wr_data, ld_result;
  logic [3:0]  byte_en;
  logic        misalign;

  be_lsu_align i_be_lsu_align (
    .base_addr(base_addr), .disp(disp), .acc_size(acc_size),
    .ld_unsigned(ld_unsigned), .st_data(st_data), .rd_word(rd_word),
    .eff_addr(eff_addr), .wr_data(wr_data), .byte_en(byte_en),
    .ld_result(ld_result), .misalign(misalign)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (size %0d off %0d uns %0d)",
               req, act, exp, acc_size, eff_addr[1:0], ld_unsigned);
    end
  endtask

  function automatic logic [7:0] lane(input logic [31:0] w, input int i);
    return w[31-8*i -: 8];
  endfunction

  task automatic run_case(input logic [31:0] target, input logic [15:0] d,
                          input logic [1:0] sz, input logic uns,
                          input logic [31:0] sd, input logic [31:0] rw);
    logic [7:0] mem [4];
    logic [7:0] expm [4];
    logic [7:0] got [4];
    logic [31:0] exp_ld;
    logic [3:0] exp_en;
    logic [31:0] exp_wd;
    logic exp_mis;
    int o, h;
    o = int'(target[1:0]);
    h = o & 2;
    base_addr = target - {{16{d[15]}}, d};
    disp = d; acc_size = sz; ld_unsigned = uns; st_data = sd; rd_word = rw;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin mem[i] = lane(rw, i); expm[i] = mem[i]; end
    exp_mis = (sz == 2'b01 && o[0]) || (sz[1] && o != 0);
    if (sz == 2'b00) begin
      exp_ld = uns ? {24'h0, mem[o]} : {{24{mem[o][7]}}, mem[o]};
      exp_en = 4'b1000 >> o;
      exp_wd = {4{sd[7:0]}};
      expm[o] = sd[7:0];
    end else if (sz == 2'b01) begin
      exp_ld = {mem[h], mem[h+1]};
      if (!uns) exp_ld[31:16] = {16{mem[h][7]}};
      exp_en = (h == 2) ? 4'b0011 : 4'b1100;
      exp_wd = {2{sd[15:0]}};
      if (!exp_mis) begin expm[o] = sd[15:8]; expm[o+1] = sd[7:0]; end
    end else begin
      exp_ld = rw;
      exp_en = 4'b1111;
      exp_wd = sd;
      if (!exp_mis) for (int i = 0; i < 4; i++) expm[i] = lane(sd, i);
    end
    if (exp_mis) exp_en = 4'b0000;
    // R1
    chk("R1 eff_addr", eff_addr, target);
    // R10
    chk("R10 misalign", {31'h0, misalign}, {31'h0, exp_mis});
    // R3 R4 R5 R11 byte enables, R2 size decode
    chk(sz == 2'b00 ? "R3 byte_en" : sz == 2'b01 ? "R4 byte_en" :
        exp_mis ? "R11 byte_en" : "R2/R5 byte_en", {28'h0, byte_en}, {28'h0, exp_en});
    // R6 replication, R5 word pass-through
    chk(sz[1] ? "R5 wr_data" : "R6 wr_data", wr_data, exp_wd);
    // R7 R8 R9 R11 load result
    chk(sz[1] ? "R9 ld_result" : uns ? "R8 ld_result" : "R7 ld_result", ld_result, exp_ld);
    // R3/R4 memory image after merging the enabled lanes
    for (int i = 0; i < 4; i++) got[i] = byte_en[3-i] ? lane(wr_data, i) : mem[i];
    chk("R4 store image", {got[0], got[1], got[2], got[3]},
        {expm[0], expm[1], expm[2], expm[3]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    logic [15:0] disps [4];
    logic [31:0] bases [3];
    pats[0] = 32'h80FF7F01; pats[1] = 32'h7F80_01FE; pats[2] = 32'hA5C3_3C5A;
    pats[3] = 32'h0000_0000; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1289_F06E;
    disps[0] = 16'h0000; disps[1] = 16'h7FFF; disps[2] = 16'h8000; disps[3] = 16'hFFFD;
    bases[0] = 32'h0000_1000; bases[1] = 32'hFFFF_FFF0; bases[2] = 32'h7FFF_FFFC;
    base_addr = '0; disp = '0; acc_size = '0; ld_unsigned = 1'b0;
    st_data = '0; rd_word = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // idle state with all-zero inputs
    chk("R3 zero-input byte_en", {28'h0, byte_en}, 32'h8);
    chk("R1 zero-input eff_addr", eff_addr, 32'h0);
    for (int b = 0; b < 3; b++)
      for (int d = 0; d < 4; d++)
        for (int s = 0; s < 4; s++)
          for (int o = 0; o < 4; o++)
            for (int u = 0; u < 2; u++)
              for (int p = 0; p < 6; p++)
                run_case(bases[b] + o, disps[d], s[1:0], u[0], pats[5-p], pats[p]);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule